// File: doc/BRIEF.md
# SMBus Master Bus-Idle Gate

This block decides when a local bus master may begin a transaction on a shared two-wire bus. It watches the clock line, the idle state of the local slave receiver and a flag that says a message is queued. When all three allow it, the block opens an idle-qualification window of a fixed number of system clocks. Only if the clock line stays quiet for the whole window does it send a one-cycle start strobe to the byte-level master engine.

The clock line comes in asynchronously and passes through a multi-flop synchronizer. Edges are taken from the synchronized value, and any edge inside the window cancels it. When the window expires, the block checks a second time that the clock line is high and the slave receiver is still idle. This catches a slave transfer that began late, and another device holding the clock low. After a start is issued, a lock holds off any new start until the master engine reports completion or loss of the bus. On a loss, the lock and the window are both dropped, so a fresh attempt follows.

Top module: `smb_idle_gate`

## Requirements
- R1: During and right after reset, `start_o`, `lock_o` and `qual_o` are all 0.
- R2: A window opens (`qual_o` goes to 1) only when `msg_pend` is 1, `slv_idle` is 1, the synchronized clock line is high and `lock_o` is 0. If any one of these is missing, `qual_o` stays 0.
- R3: If the clock line shows no transition, `start_o` goes to 1 exactly `IDLE_CYCLES` clocks after `qual_o` goes to 1, and `qual_o` falls in that same cycle.
- R4: A transition on `scl_in` during a window drops `qual_o` within `SYNC_STAGES`+1 clocks. The next start needs a new full window of `IDLE_CYCLES` clocks, counted from when `qual_o` rises again.
- R5: `start_o` is high for one clock only, and `lock_o` rises in that same clock.
- R6: While `lock_o` is 1, no further `start_o` is produced, even if every start condition keeps holding.
- R7: A 1 on `mst_done` while locked clears `lock_o` on the next clock. If `msg_pend` is still 1, a new window may then follow.
- R8: A 1 on `mst_fail` clears both `lock_o` and `qual_o` on the next clock. If the message is still pending, a later attempt produces a new start.
- R9: If `slv_idle` is 0 or the clock line is low when the window expires, no start is issued and `qual_o` returns to 0.
- R10: If `msg_pend` drops to 0 during a window, `qual_o` falls on the next clock and no start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line, asynchronous |
| msg_pend | input | 1 | A master message is queued |
| slv_idle | input | 1 | Local slave receiver is in its idle state |
| mst_done | input | 1 | Master engine finished the message |
| mst_fail | input | 1 | Master engine failed to acquire the bus |
| start_o | output | 1 | One-cycle start request to the master engine |
| lock_o | output | 1 | A launched message is in flight |
| qual_o | output | 1 | Idle-qualification window is running |

## Verification
The main function is driven with a quiet bus, with a clock transition in the middle of a window, with the message withdrawn partway through, and with the slave becoming busy just before expiry. Together these separate a window that really counts quiet time from one that is only started once or only checked at the end. Holding every start condition after a launch shows whether the lock stops a second launch. Pulsing done and fail in turn shows that each one releases the lock, and that only a fail also throws away the window.

// File: rtl/smb_gate_pkg.sv
package smb_gate_pkg;

   typedef enum logic [1:0] {
      GS_WAIT = 2'd0,
      GS_QUAL = 2'd1,
      GS_LOCK = 2'd2
   } gate_state_e;

endpackage

// File: rtl/smb_scl_sync.sv
module smb_scl_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   output logic scl_q,
   output logic scl_edge
);
   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   scl_prev;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= scl_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= 1'b1;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_prev <= 1'b1;
      else        scl_prev <= chain[SYNC_STAGES-1];
   end

   assign scl_q    = chain[SYNC_STAGES-1];
   assign scl_edge = chain[SYNC_STAGES-1] ^ scl_prev;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
   parameter int IDLE_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = (IDLE_CYCLES > 2) ? $clog2(IDLE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(IDLE_CYCLES - 1);

   initial begin
      if (IDLE_CYCLES < 2) $error("IDLE_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= RELOAD;
      else if (load)              cnt <= RELOAD;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/smb_gate_ctrl.sv
module smb_gate_ctrl
   import smb_gate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic scl_q,
   input  logic scl_edge,
   input  logic msg_pend,
   input  logic slv_idle,
   input  logic mst_done,
   input  logic mst_fail,
   input  logic expired,
   output logic tmr_load,
   output logic tmr_run,
   output logic start_o,
   output logic lock_o,
   output logic qual_o
);
   gate_state_e state, state_nx;
   logic        start_nx;
   logic        open_ok;
   logic        final_ok;

   assign open_ok  = msg_pend && slv_idle && scl_q && !scl_edge;
   assign final_ok = scl_q && slv_idle;

   always_comb begin
      state_nx = state;
      start_nx = 1'b0;
      unique case (state)
         GS_WAIT: begin
            if (open_ok) state_nx = GS_QUAL;
         end
         GS_QUAL: begin
            if (mst_fail || !msg_pend || scl_edge) begin
               state_nx = GS_WAIT;
            end else if (expired) begin
               if (final_ok) begin
                  state_nx = GS_LOCK;
                  start_nx = 1'b1;
               end else begin
                  state_nx = GS_WAIT;
               end
            end
         end
         GS_LOCK: begin
            if (mst_done || mst_fail) state_nx = GS_WAIT;
         end
         default: state_nx = GS_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= GS_WAIT;
         start_o <= 1'b0;
      end else begin
         state   <= state_nx;
         start_o <= start_nx;
      end
   end

   assign tmr_load = (state != GS_QUAL);
   assign tmr_run  = (state == GS_QUAL);
   assign lock_o   = (state == GS_LOCK);
   assign qual_o   = (state == GS_QUAL);
endmodule

// File: rtl/smb_idle_gate.sv
module smb_idle_gate #(
   parameter int SYNC_STAGES = 2,
   parameter int IDLE_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic msg_pend,
   input  logic slv_idle,
   input  logic mst_done,
   input  logic mst_fail,
   output logic start_o,
   output logic lock_o,
   output logic qual_o
);
   logic scl_q, scl_edge, expired, tmr_load, tmr_run;

   smb_scl_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_in),
      .scl_q(scl_q), .scl_edge(scl_edge)
   );

   smb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
      .expired(expired)
   );

   smb_gate_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .scl_edge(scl_edge),
      .msg_pend(msg_pend), .slv_idle(slv_idle),
      .mst_done(mst_done), .mst_fail(mst_fail), .expired(expired),
      .tmr_load(tmr_load), .tmr_run(tmr_run),
      .start_o(start_o), .lock_o(lock_o), .qual_o(qual_o)
   );
endmodule

// File: rtl/smb_idle_gate_chk.sv
module smb_idle_gate_chk #(
   parameter int IDLE_CYCLES = 100
) (
   input logic clk,
   input logic rst_n,
   input logic msg_pend,
   input logic slv_idle,
   input logic mst_done,
   input logic mst_fail,
   input logic start_o,
   input logic lock_o,
   input logic qual_o
);
   int run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_len <= 0;
      else if (!qual_o) run_len <= 0;
      else              run_len <= run_len + 1;
   end

   a_r3_full_window: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (run_len == IDLE_CYCLES));

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   a_r5_lock_with_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> lock_o);

   a_r6_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && !mst_done && !mst_fail) |=> !start_o);

   a_r8_fail_clears: assert property (@(posedge clk) disable iff (!rst_n)
      mst_fail |=> (!lock_o && !qual_o));

   a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && mst_done) |=> !lock_o);

   a_r2_open_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual_o) |-> $past(msg_pend && slv_idle));

   a_r9_start_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(slv_idle));

   a_r10_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (qual_o && !msg_pend) |=> !qual_o);
endmodule

bind smb_idle_gate smb_idle_gate_chk #(.IDLE_CYCLES(IDLE_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_pend(msg_pend), .slv_idle(slv_idle),
   .mst_done(mst_done), .mst_fail(mst_fail), .start_o(start_o),
   .lock_o(lock_o), .qual_o(qual_o)
);

// File: tb/smb_idle_gate_test.sv
module smb_idle_gate_test;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 20;
   localparam int SYNC = 2;
   localparam int WDOG = 50000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_in = 1'b1, msg_pend = 1'b0, slv_idle = 1'b1;
   logic mst_done = 1'b0, mst_fail = 1'b0;
   logic start_o, lock_o, qual_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   smb_idle_gate #(.SYNC_STAGES(SYNC), .IDLE_CYCLES(N)) uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .msg_pend(msg_pend),
      .slv_idle(slv_idle), .mst_done(mst_done), .mst_fail(mst_fail),
      .start_o(start_o), .lock_o(lock_o), .qual_o(qual_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // waits for qual_o high; returns cycles waited or -1
   task automatic wait_qual(input int lim, output int got);
      got = -1;
      for (int i = 0; i <= lim; i++) begin
         if (qual_o) begin got = i; break; end
         @(negedge clk);
      end
   endtask

   // from a negedge where qual_o was seen high, counts cycles to start_o
   task automatic count_to_start(input int lim, output int got);
      got = -1;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (start_o) begin got = i; break; end
      end
   endtask

   task automatic release_all();
      msg_pend = 1'b0;
      if (lock_o) begin
         mst_done = 1'b1; tick(1); mst_done = 1'b0;
      end
      scl_in = 1'b1; slv_idle = 1'b1;
      tick(SYNC + 3);
   endtask

   task automatic t_reset();
      check(!start_o && !lock_o && !qual_o, "R1 reset outputs",
            {start_o, lock_o, qual_o}, 0);
      tick(3);
      check(!start_o && !lock_o && !qual_o, "R1 after reset idle",
            {start_o, lock_o, qual_o}, 0);
   endtask

   task automatic t_blocked();
      int q;
      msg_pend = 1'b0; tick(2 * N);
      check(!qual_o && !start_o, "R2 no pending message", qual_o, 0);
      msg_pend = 1'b1; slv_idle = 1'b0; tick(2 * N);
      check(!qual_o && !start_o, "R2 slave busy", qual_o, 0);
      slv_idle = 1'b1; scl_in = 1'b0; tick(2 * N);
      check(!qual_o && !start_o, "R2 clock line low", qual_o, 0);
      scl_in = 1'b1;
      wait_qual(SYNC + 4, q);
      check(q >= 0, "R2 window opens when all hold", q, 1);
      release_all();
   endtask

   task automatic t_basic();
      int q, s;
      msg_pend = 1'b1;
      wait_qual(8, q);
      check(q >= 0, "R2 window opens", q, 1);
      count_to_start(3 * N, s);
      check(s == N, "R3 window length", s, N);
      check(lock_o == 1'b1, "R5 lock rises with start", lock_o, 1);
      check(qual_o == 1'b0, "R3 window closes at start", qual_o, 0);
      tick(1);
      check(start_o == 1'b0, "R5 start one cycle", start_o, 0);
   endtask

   task automatic t_lock_hold();
      int seen = 0;
      for (int i = 0; i < 3 * N; i++) begin
         @(negedge clk);
         if (start_o) seen++;
      end
      check(seen == 0, "R6 no second start while locked", seen, 0);
      check(lock_o == 1'b1, "R6 lock held", lock_o, 1);
   endtask

   task automatic t_done();
      int q, s;
      mst_done = 1'b1; tick(1); mst_done = 1'b0;
      check(lock_o == 1'b0, "R7 done clears lock", lock_o, 0);
      wait_qual(4, q);
      check(q >= 0, "R7 new window after done", q, 1);
      count_to_start(3 * N, s);
      check(s == N, "R7 second message started", s, N);
      release_all();
   endtask

   task automatic t_fail();
      int q, s;
      msg_pend = 1'b1;
      wait_qual(8, q);
      count_to_start(3 * N, s);
      check(lock_o == 1'b1, "R8 locked before fail", lock_o, 1);
      mst_fail = 1'b1; tick(1); mst_fail = 1'b0;
      check(!lock_o && !qual_o, "R8 fail clears lock and window",
            {lock_o, qual_o}, 0);
      wait_qual(4, q);
      check(q >= 0, "R8 retry window", q, 1);
      count_to_start(3 * N, s);
      check(s == N, "R8 retry start", s, N);
      // fail during a window also cancels it
      mst_done = 1'b1; tick(1); mst_done = 1'b0;
      wait_qual(4, q);
      tick(3);
      mst_fail = 1'b1; tick(1); mst_fail = 1'b0;
      check(!qual_o && !lock_o, "R8 fail cancels window", qual_o, 0);
      release_all();
   endtask

   task automatic t_edge_cancel();
      int q, s, t0, fell;
      msg_pend = 1'b1;
      wait_qual(8, q);
      t0 = cyc;
      tick(5);
      scl_in = 1'b0;
      fell = 0;
      for (int i = 1; i <= SYNC + 2; i++) begin
         @(negedge clk);
         if (!qual_o) begin fell = i; break; end
      end
      check(fell != 0, "R4 edge cancels window", fell, SYNC + 1);
      tick(3);
      scl_in = 1'b1;
      wait_qual(SYNC + 6, q);
      check(q >= 0, "R4 window reopens", q, 1);
      count_to_start(3 * N, s);
      check(s == N, "R4 full fresh window", s, N);
      check(cyc - t0 > N + 5, "R4 start delayed past first window", cyc - t0, N + 6);
      release_all();
   endtask

   task automatic t_expiry_busy();
      int q, seen = 0;
      msg_pend = 1'b1;
      wait_qual(8, q);
      tick(N - 2);
      slv_idle = 1'b0;
      for (int i = 0; i < N + 5; i++) begin
         @(negedge clk);
         if (start_o) seen++;
      end
      check(seen == 0, "R9 no start with busy slave at expiry", seen, 0);
      check(qual_o == 1'b0, "R9 back to waiting", qual_o, 0);
      slv_idle = 1'b1;
      wait_qual(4, q);
      check(q >= 0, "R9 reattempt after slave idle", q, 1);
      release_all();
   endtask

   task automatic t_pend_drop();
      int q, seen = 0;
      msg_pend = 1'b1;
      wait_qual(8, q);
      tick(4);
      msg_pend = 1'b0;
      tick(1);
      check(qual_o == 1'b0, "R10 pending drop cancels", qual_o, 1'b0);
      for (int i = 0; i < 2 * N; i++) begin
         @(negedge clk);
         if (start_o) seen++;
      end
      check(seen == 0, "R10 no start after drop", seen, 0);
      release_all();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      tick(1);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_blocked();
      t_basic();
      t_lock_hold();
      t_done();
      t_fail();
      t_edge_cancel();
      t_expiry_busy();
      t_pend_drop();
      finish_run();
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
      finish_run();
   end
endmodule